// File: doc/BRIEF.md
# Repeating Status Byte Read Path for a Serial Flash Slave

This block is the serial read path that returns a device status byte over a four-wire serial bus running in mode 0. While chip select is low, the block collects an 8-bit command on the data-in line, one bit on each rising edge of the serial clock. If the command is the status-read code, the block drives a status byte on the data-out line, one bit on each falling edge, most significant bit first. When a byte is finished, another byte follows at once. Each new byte is built from the device conditions at the moment it starts. This goes on for as long as the host keeps toggling the clock.

The top bit of the status byte is the inverse of the busy flag. While that bit is on the line, it follows the busy flag live. A host can therefore park the clock after the top bit and watch data-out rise when the device becomes ready. The block oversamples the bus pins with its own system clock through a synchronizer. Data-out carries a separate drive enable, and this enable is low whenever the block is not streaming status.

Top module: `status_stream`

## Requirements
- R1: After reset, and whenever chip select is high, `so_oe_o` is 0 and `so_o` is 0.
- R2: Command bits are captured MSB first on rising SCK edges. When the 8 captured bits equal 0x57, `so_oe_o` stays 0 until the next falling SCK edge. That edge launches bit 7 of the first status byte and sets `so_oe_o` to 1.
- R3: Any other 8-bit command leaves `so_oe_o` at 0 for the rest of that chip-select-low period, whatever SCK does afterwards.
- R4: Status bits appear on `so_o` one per falling SCK edge in the order 7 down to 0, with this layout: bit 7 = NOT busy, bit 6 = compare result, bits 5:3 = density code (bit 5 is its MSB), bits 2:0 = 0.
- R5: Bits 6:0 of a byte are sampled at the falling edge that launches that byte's bit 7. Changes to the compare or density inputs after that edge do not alter the byte in progress.
- R6: The falling edge after bit 0 launches bit 7 of a new byte, with bits 6:0 sampled fresh at that edge. This repeats without limit.
- R7: While bit 7 is being driven, `so_o` follows NOT busy within one system clock, with no SCK activity needed.
- R8: Raising chip select in the middle of a stream drops `so_oe_o` to 0. The next chip-select-low period starts a fresh command capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock, idles low |
| si_i | input | 1 | Serial data in |
| busy_i | input | 1 | Device busy flag |
| cmp_i | input | 1 | Compare result bit |
| dens_i | input | DENS_W | Density code |
| so_o | output | 1 | Serial data out value |
| so_oe_o | output | 1 | Drive enable for data out; 0 means high impedance |

## Verification
The assertions assume that every SCK or chip-select transition is held for at least SYNC_STAGES+2 system clocks. They also assume SI is stable around each SCK rise, and that SCK is low when chip select falls, so that the synchronized edges arrive in the bus order. The bench meets these assumptions by holding each SCK half period for 8 system clocks. It changes every input only on falling system-clock edges, and it always lowers SCK before it raises chip select. The busy, compare and density inputs come from the system-clock domain, so the assertions treat them as synchronous.

// File: rtl/status_stream_pkg.sv
package status_stream_pkg;
  parameter int unsigned OP_W        = 8;
  parameter int unsigned STAT_W      = 8;
  parameter int unsigned DENS_W      = 3;
  parameter int unsigned SYNC_STAGES = 2;
  parameter logic [OP_W-1:0] STATUS_OP = 8'h57;

  localparam int unsigned RSVD_W   = STAT_W - 2 - DENS_W;
  localparam int unsigned OP_CNT_W = $clog2(OP_W);
  localparam int unsigned IDX_W    = $clog2(STAT_W);

  typedef enum logic [1:0] {
    RX_OPCODE,
    RX_ARMED,
    RX_IGNORE
  } rx_state_e;
endpackage

// File: rtl/ss_pin_sync.sv
module ss_pin_sync #(
  parameter int unsigned W       = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [W-1:0]             prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
      prev_q <= RST_VAL;
    end else begin
      stg_q[0] <= pin_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign sync_o = stg_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/ss_cmd_rx.sv
module ss_cmd_rx
  import status_stream_pkg::*;
#(
  parameter int unsigned        CMD_W   = OP_W,
  parameter int unsigned        CNT_W   = OP_CNT_W,
  parameter logic [CMD_W-1:0]   MATCH_OP = STATUS_OP
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic rise_i,
  input  logic si_i,
  output logic arm_o
);
  rx_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CMD_W-1:0] sr_q, sr_n;

  assign sr_n = {sr_q[CMD_W-2:0], si_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_OPCODE;
      cnt_q   <= '0;
      sr_q    <= '0;
    end else if (clr_i) begin
      state_q <= RX_OPCODE;
      cnt_q   <= '0;
      sr_q    <= '0;
    end else if (rise_i && state_q == RX_OPCODE) begin
      sr_q  <= sr_n;
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_W'(CMD_W-1))
        state_q <= (sr_n == MATCH_OP) ? RX_ARMED : RX_IGNORE;
    end
  end

  assign arm_o = (state_q == RX_ARMED);

  // arming only after a full command
  p_full_cmd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(arm_o) |-> ($past(rise_i) && $past(cnt_q) == CNT_W'(CMD_W-1)));

  // a rejected command stays rejected until deselect
  p_ignore_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RX_IGNORE && !clr_i) |=> (state_q == RX_IGNORE));
endmodule

// File: rtl/ss_byte_tx.sv
module ss_byte_tx
  import status_stream_pkg::*;
#(
  parameter int unsigned BYTE_W = STAT_W,
  parameter int unsigned DW     = DENS_W,
  parameter int unsigned IW     = IDX_W,
  parameter int unsigned RW     = RSVD_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          arm_i,
  input  logic          fall_i,
  input  logic          busy_i,
  input  logic          cmp_i,
  input  logic [DW-1:0] dens_i,
  output logic          so_o,
  output logic          oe_o
);
  localparam logic [IW-1:0] TOP = IW'(BYTE_W-1);

  logic              active_q, active_n;
  logic [IW-1:0]     idx_q, idx_n;
  logic [BYTE_W-1:0] snap_q, snap_n, fresh;
  logic              so_q, bit_n;

  // top bit is a placeholder; it is driven live from busy
  assign fresh = {1'b0, cmp_i, dens_i, {RW{1'b0}}};

  always_comb begin
    active_n = active_q;
    idx_n    = idx_q;
    snap_n   = snap_q;
    if (clr_i) begin
      active_n = 1'b0;
      idx_n    = TOP;
    end else if (fall_i) begin
      if (!active_q && arm_i) begin
        active_n = 1'b1;
        idx_n    = TOP;
        snap_n   = fresh;
      end else if (active_q) begin
        if (idx_q == '0) begin
          idx_n  = TOP;
          snap_n = fresh;
        end else begin
          idx_n = idx_q - 1'b1;
        end
      end
    end
    bit_n = (idx_n == TOP) ? ~busy_i : snap_n[idx_n];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= TOP;
      snap_q   <= '0;
      so_q     <= 1'b0;
    end else begin
      active_q <= active_n;
      idx_q    <= idx_n;
      snap_q   <= snap_n;
      so_q     <= active_n & bit_n;
    end
  end

  assign so_o = so_q;
  assign oe_o = active_q;

  p_start_armed_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_q) |-> $past(arm_i && fall_i));

  p_rsvd_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && idx_q < IW'(RW)) |-> !so_o);

  p_snap_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !fall_i && !clr_i) |=> $stable(snap_q));

  p_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && idx_q == '0 && fall_i && !clr_i) |=> (active_q && idx_q == TOP));

  p_ready_live_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && idx_q == TOP && !fall_i && !clr_i) |=> (so_o == !$past(busy_i)));
endmodule

// File: rtl/status_stream.sv
module status_stream
  import status_stream_pkg::*;
#(
  parameter int unsigned DW     = DENS_W,
  parameter int unsigned STAGES = SYNC_STAGES
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          sck_i,
  input  logic          si_i,
  input  logic          busy_i,
  input  logic          cmp_i,
  input  logic [DW-1:0] dens_i,
  output logic          so_o,
  output logic          so_oe_o
);
  localparam int unsigned PIN_W = 3;

  logic [PIN_W-1:0] pin_s, pin_p;
  logic cs_s, sck_s, sck_p, si_s;
  logic rise, fall, arm;

  ss_pin_sync #(
    .W      (PIN_W),
    .STAGES (STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i ({cs_ni, sck_i, si_i}),
    .sync_o(pin_s),
    .prev_o(pin_p)
  );

  assign cs_s  = pin_s[2];
  assign sck_s = pin_s[1];
  assign si_s  = pin_s[0];
  assign sck_p = pin_p[1];
  assign rise  = !cs_s &&  sck_s && !sck_p;
  assign fall  = !cs_s && !sck_s &&  sck_p;

  ss_cmd_rx u_rx (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cs_s),
    .rise_i(rise),
    .si_i  (si_s),
    .arm_o (arm)
  );

  ss_byte_tx #(.DW(DW)) u_tx (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cs_s),
    .arm_i (arm),
    .fall_i(fall),
    .busy_i(busy_i),
    .cmp_i (cmp_i),
    .dens_i(dens_i),
    .so_o  (so_o),
    .oe_o  (so_oe_o)
  );

  // deselect releases the line (R1, R8)
  p_hiz_cs_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> (!so_oe_o && !so_o));

  p_no_oe_without_arm_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!so_oe_o && !arm) |=> !so_oe_o);
endmodule

// File: tb/status_stream_test.sv
module status_stream_test;
  localparam int HALF = 8;
  localparam int NV   = 5;
  // {busy, cmp, dens[2:0], expected byte}
  localparam logic [12:0] VEC [NV] = '{
    {1'b0, 1'b0, 3'b000, 8'h80},
    {1'b1, 1'b1, 3'b111, 8'h78},
    {1'b0, 1'b1, 3'b101, 8'hE8},
    {1'b1, 1'b0, 3'b010, 8'h10},
    {1'b0, 1'b0, 3'b011, 8'h98}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0;
  logic busy = 1'b0, cmp = 1'b0;
  logic [2:0] dens = '0;
  logic so, so_oe;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  status_stream uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .si_i(si),
    .busy_i(busy), .cmp_i(cmp), .dens_i(dens), .so_o(so), .so_oe_o(so_oe)
  );

  function automatic logic [7:0] exp_byte(logic b, logic c, logic [2:0] d);
    return {~b, c, d, 3'b000};
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cs_begin();
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic cs_end();
    sck = 1'b0;
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(HALF);
  endtask

  // leaves SCK high after the last rise
  task automatic send_op(input logic [7:0] op);
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0;
      si = op[i];
      wait_clk(HALF);
      sck = 1'b1;
      wait_clk(HALF);
    end
  endtask

  task automatic read_bit(output logic b, output logic oe);
    sck = 1'b0;
    wait_clk(HALF);
    b = so;
    oe = so_oe;
    sck = 1'b1;
    wait_clk(HALF);
  endtask

  task automatic read_byte(output logic [7:0] b, output logic oe_all);
    logic oe;
    oe_all = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      read_bit(b[i], oe);
      oe_all &= oe;
    end
  endtask

  initial begin
    logic [7:0] got;
    logic oe_ok, bt, oe;
    logic [7:0] old_exp;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(2);
    check(!so_oe && !so, "R1 reset idle", {so_oe, so}, 0);

    // table walk: R2, R4
    for (int v = 0; v < NV; v++) begin
      {busy, cmp, dens} = VEC[v][12:8];
      cs_begin();
      send_op(8'h57);
      if (v == 0) check(!so_oe, "R2 no drive before launch", so_oe, 0);
      read_byte(got, oe_ok);
      check(got == VEC[v][7:0], "R4 status byte", got, VEC[v][7:0]);
      check(oe_ok, "R2 drive enable while streaming", oe_ok, 1);
      cs_end();
      check(!so_oe, "R1 deselect hiz", so_oe, 0);
    end

    // R3: other command ignored
    cs_begin();
    send_op(8'h58);
    oe_ok = 1'b0;
    for (int i = 0; i < 16; i++) begin
      read_bit(bt, oe);
      oe_ok |= oe;
    end
    check(!oe_ok, "R3 foreign command keeps hiz", oe_ok, 0);
    cs_end();

    // R5, R6, R7 in one stream
    busy = 1'b1; cmp = 1'b1; dens = 3'b110;
    old_exp = exp_byte(1'b1, 1'b1, 3'b110);
    cs_begin();
    send_op(8'h57);
    sck = 1'b0;
    wait_clk(HALF);
    check(so == 1'b0, "R7 busy shows 0", so, 0);
    busy = 1'b0;
    wait_clk(3);
    check(so == 1'b1, "R7 parked bit follows ready", so, 1);
    cmp = 1'b0; dens = 3'b001;
    sck = 1'b1;
    wait_clk(HALF);
    got = '0;
    for (int i = 6; i >= 0; i--) read_bit(got[i], oe);
    check(got[6:0] == old_exp[6:0], "R5 byte frozen at launch", got[6:0], old_exp[6:0]);
    read_byte(got, oe_ok);
    check(got == exp_byte(1'b0, 1'b0, 3'b001), "R6 next byte resampled", got, exp_byte(1'b0, 1'b0, 3'b001));
    busy = 1'b1; dens = 3'b100;
    read_byte(got, oe_ok);
    check(got == exp_byte(1'b1, 1'b0, 3'b100) && oe_ok, "R6 third byte", got, exp_byte(1'b1, 1'b0, 3'b100));

    // R8: abort mid-byte, then restart
    for (int i = 0; i < 3; i++) read_bit(bt, oe);
    cs_end();
    check(!so_oe && !so, "R8 abort releases line", {so_oe, so}, 0);
    busy = 1'b0; cmp = 1'b1; dens = 3'b011;
    cs_begin();
    send_op(8'h57);
    read_byte(got, oe_ok);
    check(got == exp_byte(1'b0, 1'b1, 3'b011) && oe_ok, "R8 fresh capture after abort", got, exp_byte(1'b0, 1'b1, 3'b011));
    cs_end();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule